// File: doc/BRIEF.md
# Shared Serial Pin Ownership Multiplexer

This block decides which of two on-chip peripherals drives a small group of device pins: a configuration-EEPROM controller that loads bus configuration after reset, or a synchronous serial port that the application uses afterwards. A mode-select input picks the owner. Every reset hands the pins to the EEPROM side. Software later moves them to the serial port, normally by driving a general-purpose output high once configuration has finished. A static bus-enable strap permits the EEPROM side at all; when the strap is low, the serial port is the only possible owner.

Three pins are shared: the transmit clock doubles as the EEPROM clock, the receive data doubles as the EEPROM data output, and the transmit data doubles as the EEPROM data input. The EEPROM chip select has its own pin, and the block holds it low whenever the EEPROM does not own the group. Each ownership change passes through a handover gap in which no shared output enable is active and the incoming shared data is forced to zero toward both peripherals. The serial port's external clock-source pin is also shared with one general-purpose I/O bit, and that bit's enable takes priority.

Top module: `serial_pin_share`

## Requirements
- R1: After reset with the strap high and mode-select low, the EEPROM side owns the shared pins. The pad output enables and values follow the EEPROM controller, EEPROM data-out reaches the controller, and the chip select follows the controller.
- R2: With the strap high and mode-select at 1, the serial port owns the shared pins once the handover completes. Its output enables and values drive the pads, and the pad receive data and transmit clock reach it.
- R3: Mode-select passes through a two-flop synchronizer. For the two cycles after a change, ownership stays as it was, and the handover gap starts in the third cycle.
- R4: On every ownership change, both shared output enables are low for GAP_CYCLES cycles (default 2) before the new owner's enables can turn on. Both owners are never selected at once.
- R5: During the handover gap, the receive data and transmit clock inputs toward both peripherals read 0.
- R6: The pad chip select is 0 whenever the EEPROM side is not the owner, including during the gap.
- R7: With the strap low, the serial port takes the pins after the reset-time gap, the chip select stays 0, and mode-select has no effect.
- R8: When the GPIO enable bit is 1, the clock-source pin belongs to GPIO. Its output enable equals the GPIO direction bit (1 means output), its value equals the GPIO value bit, the pin reaches the GPIO input, and the serial port's clock source reads 0. When the enable bit is 0, the pin's output enable is 0 and the pin reaches only the serial port.
- R9: A return from serial mode to EEPROM mode passes through the same gap.
- R10: The peripheral that does not own the pins sees 0 on its shared inputs.
- R11: If mode-select changes again during a gap, the pins settle on the owner given by the latest mode-select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_bus_en | input | 1 | Static strap; 1 permits EEPROM ownership |
| mode_sel | input | 1 | 0 = EEPROM owner, 1 = serial owner (asynchronous) |
| ee_sclk_o | input | 1 | EEPROM controller clock out |
| ee_sclk_oe | input | 1 | EEPROM controller clock enable |
| ee_mosi_o | input | 1 | EEPROM controller data toward EEPROM |
| ee_mosi_oe | input | 1 | Enable for that data |
| ee_cs_o | input | 1 | EEPROM controller chip select |
| ee_miso_i | output | 1 | EEPROM data-out toward controller |
| sp_txclk_o | input | 1 | Serial transmit clock out |
| sp_txclk_oe | input | 1 | Serial transmit clock enable |
| sp_txd_o | input | 1 | Serial transmit data |
| sp_txd_oe | input | 1 | Serial transmit data enable |
| sp_txclk_i | output | 1 | Transmit clock pin value toward the serial port |
| sp_rxd_i | output | 1 | Receive data toward the serial port |
| sp_clks_i | output | 1 | Clock-source pin value toward the serial port |
| gpio_en | input | 1 | GPIO enable for the clock-source bit |
| gpio_dir | input | 1 | GPIO direction, 1 = output |
| gpio_val | input | 1 | GPIO output value |
| gpio_in | output | 1 | Clock-source pin value toward GPIO |
| pad_tclk_i | input | 1 | Shared clock pin input |
| pad_tclk_o | output | 1 | Shared clock pin output |
| pad_tclk_oe | output | 1 | Shared clock pin enable |
| pad_rdat_i | input | 1 | Shared receive data pin |
| pad_tdat_o | output | 1 | Shared transmit data pin output |
| pad_tdat_oe | output | 1 | Shared transmit data pin enable |
| pad_cs_o | output | 1 | EEPROM chip select pin |
| pad_clks_i | input | 1 | Clock-source pin input |
| pad_clks_o | output | 1 | Clock-source pin output |
| pad_clks_oe | output | 1 | Clock-source pin enable |

## Verification
The ownership handover and the GPIO override of the clock-source pin act on separate pins, but they can change in the same cycle. The bench turns on the GPIO bit as an output while the handover gap is open. In that cycle it expects the clock-source pin to be driven by GPIO while both shared enables stay low and the shared inputs read zero. It also changes mode-select back during a gap, to show that the pins settle on the latest request.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    ST_EE  = 2'd0,
    ST_GAP = 2'd1,
    ST_SP  = 2'd2
  } own_state_e;

  typedef enum logic {
    OWN_EE = 1'b0,
    OWN_SP = 1'b1
  } owner_e;

  // Requested owner from the strap and the synchronized mode bit.
  function automatic owner_e pick_owner(input logic strap, input logic mode);
    return (strap && !mode) ? OWN_EE : OWN_SP;
  endfunction

  // Steered output bit: selected driver's value, or 0 when nobody owns.
  function automatic logic steer_bit(input logic ee_sel, input logic sp_sel,
                                     input logic ee_v, input logic sp_v);
    return (ee_sel & ee_v) | (sp_sel & sp_v);
  endfunction

endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sps_handover.sv
module sps_handover
  import sps_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e target,
  output logic   ee_hold,
  output logic   sp_sel,
  output logic   gap_active
);
  localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

  own_state_e    state;
  logic [CW-1:0] cnt;
  logic          gap_last;

  assign gap_last = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_EE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_EE: if (target == OWN_SP) begin
          state <= ST_GAP;
          cnt   <= CW'(GAP_CYCLES);
        end
        ST_SP: if (target == OWN_EE) begin
          state <= ST_GAP;
          cnt   <= CW'(GAP_CYCLES);
        end
        ST_GAP: begin
          if (gap_last) state <= (target == OWN_SP) ? ST_SP : ST_EE;
          else          cnt   <= cnt - CW'(1);
        end
        default: state <= ST_EE;
      endcase
    end
  end

  assign ee_hold    = (state == ST_EE);
  assign sp_sel     = (state == ST_SP);
  assign gap_active = (state == ST_GAP);
endmodule

// File: rtl/sps_steer.sv
module sps_steer
  import sps_pkg::*;
(
  input  logic ee_sel,
  input  logic sp_sel,
  input  logic ee_sclk_o,
  input  logic ee_sclk_oe,
  input  logic ee_mosi_o,
  input  logic ee_mosi_oe,
  input  logic ee_cs_o,
  input  logic sp_txclk_o,
  input  logic sp_txclk_oe,
  input  logic sp_txd_o,
  input  logic sp_txd_oe,
  input  logic pad_tclk_i,
  input  logic pad_rdat_i,
  input  logic pad_clks_i,
  input  logic gpio_en,
  input  logic gpio_dir,
  input  logic gpio_val,
  output logic pad_tclk_o,
  output logic pad_tclk_oe,
  output logic pad_tdat_o,
  output logic pad_tdat_oe,
  output logic pad_cs_o,
  output logic pad_clks_o,
  output logic pad_clks_oe,
  output logic ee_miso_i,
  output logic sp_txclk_i,
  output logic sp_rxd_i,
  output logic sp_clks_i,
  output logic gpio_in
);
  logic gpio_drives;

  always_comb begin
    pad_tclk_o  = steer_bit(ee_sel, sp_sel, ee_sclk_o,  sp_txclk_o);
    pad_tclk_oe = steer_bit(ee_sel, sp_sel, ee_sclk_oe, sp_txclk_oe);
    pad_tdat_o  = steer_bit(ee_sel, sp_sel, ee_mosi_o,  sp_txd_o);
    pad_tdat_oe = steer_bit(ee_sel, sp_sel, ee_mosi_oe, sp_txd_oe);
    pad_cs_o    = ee_sel & ee_cs_o;
    ee_miso_i   = ee_sel & pad_rdat_i;
    sp_rxd_i    = sp_sel & pad_rdat_i;
    sp_txclk_i  = sp_sel & pad_tclk_i;
  end

  assign gpio_drives = gpio_en & gpio_dir;
  assign pad_clks_oe = gpio_drives;
  assign pad_clks_o  = gpio_drives & gpio_val;
  assign gpio_in     = gpio_en & pad_clks_i;
  assign sp_clks_i   = ~gpio_en & pad_clks_i;
endmodule

// File: rtl/serial_pin_share.sv
module serial_pin_share
  import sps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_bus_en,
  input  logic mode_sel,
  input  logic ee_sclk_o,
  input  logic ee_sclk_oe,
  input  logic ee_mosi_o,
  input  logic ee_mosi_oe,
  input  logic ee_cs_o,
  output logic ee_miso_i,
  input  logic sp_txclk_o,
  input  logic sp_txclk_oe,
  input  logic sp_txd_o,
  input  logic sp_txd_oe,
  output logic sp_txclk_i,
  output logic sp_rxd_i,
  output logic sp_clks_i,
  input  logic gpio_en,
  input  logic gpio_dir,
  input  logic gpio_val,
  output logic gpio_in,
  input  logic pad_tclk_i,
  output logic pad_tclk_o,
  output logic pad_tclk_oe,
  input  logic pad_rdat_i,
  output logic pad_tdat_o,
  output logic pad_tdat_oe,
  output logic pad_cs_o,
  input  logic pad_clks_i,
  output logic pad_clks_o,
  output logic pad_clks_oe
);
  logic   mode_sync;
  owner_e target;
  logic   ee_hold;
  logic   ee_sel;
  logic   sp_sel;
  logic   gap_active;

  sps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mode_sel), .q(mode_sync)
  );

  assign target = pick_owner(strap_bus_en, mode_sync);

  sps_handover #(.GAP_CYCLES(GAP_CYCLES)) u_hand (
    .clk(clk), .rst_n(rst_n), .target(target),
    .ee_hold(ee_hold), .sp_sel(sp_sel), .gap_active(gap_active)
  );

  assign ee_sel = ee_hold & strap_bus_en;

  sps_steer u_steer (
    .ee_sel(ee_sel), .sp_sel(sp_sel),
    .ee_sclk_o(ee_sclk_o), .ee_sclk_oe(ee_sclk_oe),
    .ee_mosi_o(ee_mosi_o), .ee_mosi_oe(ee_mosi_oe), .ee_cs_o(ee_cs_o),
    .sp_txclk_o(sp_txclk_o), .sp_txclk_oe(sp_txclk_oe),
    .sp_txd_o(sp_txd_o), .sp_txd_oe(sp_txd_oe),
    .pad_tclk_i(pad_tclk_i), .pad_rdat_i(pad_rdat_i), .pad_clks_i(pad_clks_i),
    .gpio_en(gpio_en), .gpio_dir(gpio_dir), .gpio_val(gpio_val),
    .pad_tclk_o(pad_tclk_o), .pad_tclk_oe(pad_tclk_oe),
    .pad_tdat_o(pad_tdat_o), .pad_tdat_oe(pad_tdat_oe),
    .pad_cs_o(pad_cs_o), .pad_clks_o(pad_clks_o), .pad_clks_oe(pad_clks_oe),
    .ee_miso_i(ee_miso_i), .sp_txclk_i(sp_txclk_i), .sp_rxd_i(sp_rxd_i),
    .sp_clks_i(sp_clks_i), .gpio_in(gpio_in)
  );
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic clk,
  input logic rst_n,
  input logic strap_bus_en,
  input logic ee_sel,
  input logic sp_sel,
  input logic gap_active,
  input logic pad_tclk_oe,
  input logic pad_tdat_oe,
  input logic pad_cs_o,
  input logic ee_miso_i,
  input logic sp_rxd_i,
  input logic sp_txclk_i,
  input logic sp_clks_i,
  input logic gpio_en
);
  AST_GAP_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> (!pad_tclk_oe && !pad_tdat_oe)); // R4

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_sel && sp_sel)); // R4

  AST_SP_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sp_sel) |-> $past(gap_active)); // R4

  AST_EE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sp_sel) |-> (gap_active && !ee_sel)); // R9

  AST_GAP_INPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> (!ee_miso_i && !sp_rxd_i && !sp_txclk_i)); // R5

  AST_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_sel |-> !pad_cs_o); // R6

  AST_STRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_bus_en |-> !ee_sel); // R7

  AST_GPIO_TAKES_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_en |-> !sp_clks_i); // R8
endmodule

bind serial_pin_share sps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .strap_bus_en(strap_bus_en),
  .ee_sel(ee_sel), .sp_sel(sp_sel), .gap_active(gap_active),
  .pad_tclk_oe(pad_tclk_oe), .pad_tdat_oe(pad_tdat_oe), .pad_cs_o(pad_cs_o),
  .ee_miso_i(ee_miso_i), .sp_rxd_i(sp_rxd_i), .sp_txclk_i(sp_txclk_i),
  .sp_clks_i(sp_clks_i), .gpio_en(gpio_en)
);

// File: tb/serial_pin_share_test.sv
module serial_pin_share_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_bus_en = 1'b1, mode_sel = 1'b0;
  logic ee_sclk_o = 1'b1, ee_sclk_oe = 1'b1, ee_mosi_o = 1'b1, ee_mosi_oe = 1'b1;
  logic ee_cs_o = 1'b1;
  logic sp_txclk_o = 1'b0, sp_txclk_oe = 1'b1, sp_txd_o = 1'b0, sp_txd_oe = 1'b1;
  logic gpio_en = 1'b0, gpio_dir = 1'b0, gpio_val = 1'b0;
  logic pad_tclk_i = 1'b1, pad_rdat_i = 1'b1, pad_clks_i = 1'b0;
  logic ee_miso_i, sp_txclk_i, sp_rxd_i, sp_clks_i, gpio_in;
  logic pad_tclk_o, pad_tclk_oe, pad_tdat_o, pad_tdat_oe, pad_cs_o;
  logic pad_clks_o, pad_clks_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_pin_share uut (.*);

  // Owner view: {tclk_oe, tclk_o, tdat_oe, tdat_o, ee_miso, sp_rxd, sp_txclk_i, cs}
  localparam logic [7:0] V_EE  = 8'b1111_1001;
  localparam logic [7:0] V_GAP = 8'b0000_0000;
  localparam logic [7:0] V_SP  = 8'b1010_0110;

  // {gpio_en, gpio_dir, gpio_val, pad_clks_i, exp_oe, exp_o, exp_gpio_in, exp_sp_clks}
  localparam logic [7:0] CLKS_VEC [8] = '{
    8'b0001_0001, 8'b0110_0000, 8'b0111_0001, 8'b1011_0010,
    8'b1000_0000, 8'b1110_1100, 8'b1101_1010, 8'b1111_1110
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] view();
    return {pad_tclk_oe, pad_tclk_o, pad_tdat_oe, pad_tdat_o,
            ee_miso_i, sp_rxd_i, sp_txclk_i, pad_cs_o};
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; strap_bus_en = strap; mode_sel = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R8: clock-source pin table
    for (int i = 0; i < 8; i++) begin
      {gpio_en, gpio_dir, gpio_val, pad_clks_i} = CLKS_VEC[i][7:4];
      #1;
      check({4'b0, pad_clks_oe, pad_clks_o, gpio_in, sp_clks_i},
            {4'b0, CLKS_VEC[i][3:0]}, "R8 clock-source steering");
    end
    gpio_en = 1'b0; gpio_dir = 1'b0; gpio_val = 1'b0;

    // R1: reset state
    do_reset(1'b1);
    #1; check(view(), V_EE, "R1 reset owner EEPROM");
    step(); check(view(), V_EE, "R1 EEPROM steady");

    // R3/R4/R5/R2: switch to serial
    mode_sel = 1'b1;
    step(); check(view(), V_EE, "R3 sync cycle 1");
    step(); check(view(), V_EE, "R3 sync cycle 2");
    step(); check(view(), V_GAP, "R4 R5 gap cycle 1");
    // Same-cycle GPIO takeover during gap
    gpio_en = 1'b1; gpio_dir = 1'b1; gpio_val = 1'b1; #1;
    check({6'b0, pad_clks_oe, pad_clks_o}, 8'b11, "R8 GPIO drives during gap");
    check(view(), V_GAP, "R4 gap unaffected by GPIO");
    step(); check(view(), V_GAP, "R4 R6 gap cycle 2");
    step(); check(view(), V_SP, "R2 R10 serial owns");
    gpio_en = 1'b0; gpio_dir = 1'b0; gpio_val = 1'b0;
    step(); check(view(), V_SP, "R2 serial steady");

    // R9: back to EEPROM
    mode_sel = 1'b0;
    step(); step(); check(view(), V_SP, "R9 sync holds serial");
    step(); check(view(), V_GAP, "R9 gap 1");
    step(); check(view(), V_GAP, "R9 gap 2");
    step(); check(view(), V_EE, "R9 EEPROM owns again");

    // R11: change request again while the gap is open
    mode_sel = 1'b1;
    step(); step(); step(); check(view(), V_GAP, "R11 gap opened");
    mode_sel = 1'b0;
    repeat (10) step();
    check(view(), V_EE, "R11 latest request EEPROM");

    // R7: strap low
    do_reset(1'b0);
    #1; check(view(), V_GAP, "R7 nobody owns right after reset");
    step(); check(view(), V_GAP, "R7 reset gap 1");
    step(); check(view(), V_GAP, "R7 reset gap 2");
    step(); check(view(), V_SP, "R7 serial owns with strap low");
    mode_sel = 1'b1;
    repeat (4) step();
    mode_sel = 1'b0;
    repeat (6) step();
    check(view(), V_SP, "R7 mode-select ignored, cs low");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule